// File: doc/BRIEF.md
# Dual-Dispatch Reservation Station with Same-Cycle Broadcast Capture

This block is a small pool of waiting slots for instructions in an out-of-order core that dispatches two instructions per cycle. Each dispatched instruction brings two physical source tags, a readiness bit for each source and a physical destination tag. The station keeps only whether each operand is available, not the operand value. Two result-tag broadcast buses are watched every cycle. Any waiting source whose tag matches a valid broadcast is marked available.

A source tag that matches a broadcast in the same cycle it is dispatched is written as available. This holds for either bus, either source and either dispatch slot, so such an instruction is not left waiting forever. In each cycle, the lowest-numbered entry with both sources available is chosen. Its tags and index appear on a registered issue port one cycle later, and register values can be fetched on the way to execute. The issued entry is freed by the same clock edge. A flush input empties the whole pool in one cycle.

Top module: `rs_station`

## Requirements
- R1: After reset, every entry is empty, `issue_vld` is 0 and `disp_stall` is 0 while no dispatch is requested.
- R2: Requesting dispatch slots take the lowest-numbered free entries in slot order: slot 0 gets the lowest and slot 1 the next. A lone slot 1 request takes the lowest free entry.
- R3: `disp_stall` is 1 in any cycle where the number of requesting slots exceeds the number of free entries. In such a cycle, neither slot is written.
- R4: When a stored source tag of a valid entry equals the tag on either broadcast bus whose valid bit is set, that source becomes available at the clock edge. The entry can be selected in the following cycle.
- R5: When a dispatching source tag equals a valid broadcast tag in its dispatch cycle, it is stored as available. This applies to both buses, both sources and both slots.
- R6: A broadcast whose tag matches no waiting source leaves every entry waiting, and no issue results.
- R7: Each cycle, the lowest-numbered valid entry with both sources available is selected. At the next edge, `issue_vld` becomes 1 with that entry's index and tags. An entry dispatched with both sources ready at edge k shows on the issue port after edge k+1.
- R8: An issued entry is freed by the edge that captures its issue, so each dispatched instruction appears on the issue port exactly once.
- R9: Flush empties all entries and clears `issue_vld` at the next edge. It overrides a dispatch and an issue capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the whole station |
| disp_vld | input | 2 | Dispatch request per slot |
| disp_tag_a | input | 2x6 | Source A tag per slot |
| disp_rdy_a | input | 2 | Source A already available per slot |
| disp_tag_b | input | 2x6 | Source B tag per slot |
| disp_rdy_b | input | 2 | Source B already available per slot |
| disp_dst | input | 2x6 | Destination tag per slot |
| disp_stall | output | 1 | Not enough free entries; nothing written |
| cdb_vld | input | 2 | Broadcast valid per bus |
| cdb_tag | input | 2x6 | Broadcast tag per bus |
| issue_vld | output | 1 | Issue port holds an instruction |
| issue_idx | output | 3 | Entry index of the issued instruction |
| issue_tag_a | output | 6 | Source A tag of the issued instruction |
| issue_tag_b | output | 6 | Source B tag of the issued instruction |
| issue_dst | output | 6 | Destination tag of the issued instruction |

## Verification
Instructions dispatched fully ready are compared against instructions woken later by each bus and each source position. This shows whether the compare network covers every combination and whether the wakeup-to-issue latency is right. Dispatches that coincide with a matching broadcast on the opposite bus are used to distinguish the capture path from ordinary wakeup: without the capture path, such an instruction never issues. A pool filled to within one and then two entries of full shows whether the stall counts free entries correctly, since a wrongly accepted instruction that is already ready would issue ahead of the waiting ones. Simultaneous wakeups of several entries, flush cycles that overlap dispatch or issue capture, and broadcasts with non-matching tags show the selection order and which actions are dropped.

// File: rtl/rs_pkg.sv
// Shared types and helpers for the reservation station.
// Assumes all tags share one width, set here for the whole project.
package rs_pkg;
    parameter int TAG_W  = 6;
    parameter int NSLOT  = 2;
    parameter int NBUS   = 2;

    typedef logic [TAG_W-1:0] tag_t;

    // One stored or incoming instruction's availability record.
    typedef struct packed {
        logic vld;
        logic rdy_a;
        logic rdy_b;
        tag_t tag_a;
        tag_t tag_b;
        tag_t dst;
    } rs_ent_t;

    // True when tag equals any valid broadcast tag.
    function automatic logic bus_hit(input tag_t t,
                                     input logic [NBUS-1:0] bvld,
                                     input tag_t [NBUS-1:0] btag);
        logic h;
        h = 1'b0;
        for (int b = 0; b < NBUS; b++)
            h = h | (bvld[b] && (btag[b] == t));
        return h;
    endfunction
endpackage

// File: rtl/rs_alloc.sv
// Free-entry finder for the two dispatch slots.
// Grants the two lowest free entries in slot order; raises stall and
// grants nothing when free entries are fewer than requests.
module rs_alloc #(
    parameter int N = 8
) (
    input  logic [N-1:0] free_vec,
    input  logic [1:0]   req,
    output logic [N-1:0] grant0,
    output logic [N-1:0] grant1,
    output logic         stall
);
    logic [N-1:0] first_oh;
    logic [N-1:0] rest;
    logic [N-1:0] second_oh;

    // Isolate the lowest and second-lowest free entries.
    always_comb begin
        first_oh  = free_vec & (~free_vec + N'(1));
        rest      = free_vec & ~first_oh;
        second_oh = rest & (~rest + N'(1));
    end

    // Decide stall and hand out entries to requesting slots.
    always_comb begin
        stall = ((req == 2'b11) && (second_oh == '0)) ||
                ((req != 2'b00) && (first_oh == '0));
        grant0 = '0;
        grant1 = '0;
        if (!stall) begin
            if (req[0]) grant0 = first_oh;
            if (req[1]) grant1 = req[0] ? second_oh : first_oh;
        end
    end
endmodule

// File: rtl/rs_entry.sv
// One station entry: holds availability of two sources and the tags.
// Incoming sources are checked against the broadcasts of the same cycle
// so a result passing on the bus while dispatching is not missed.
module rs_entry
    import rs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 wr_en,
    input  rs_ent_t              wr_data,
    input  logic                 clr,
    input  logic [NBUS-1:0]      bvld,
    input  tag_t [NBUS-1:0]      btag,
    output rs_ent_t              ent
);
    rs_ent_t nxt;

    // Compute next state: write with bypass, wake, or free.
    always_comb begin
        nxt = ent;
        if (wr_en) begin
            nxt       = wr_data;
            nxt.vld   = 1'b1;
            nxt.rdy_a = wr_data.rdy_a | bus_hit(wr_data.tag_a, bvld, btag);
            nxt.rdy_b = wr_data.rdy_b | bus_hit(wr_data.tag_b, bvld, btag);
        end else if (clr) begin
            nxt.vld = 1'b0;
        end else if (ent.vld) begin
            nxt.rdy_a = ent.rdy_a | bus_hit(ent.tag_a, bvld, btag);
            nxt.rdy_b = ent.rdy_b | bus_hit(ent.tag_b, bvld, btag);
        end
    end

    // State register with reset and flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) ent <= '0;
        else                 ent <= nxt;
    end
endmodule

// File: rtl/rs_select.sv
// Picks the lowest-index requesting entry and encodes its index.
module rs_select #(
    parameter int N     = 8,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  pick_oh,
    output logic          any,
    output logic [IW-1:0] pick_idx
);
    // Lowest-set isolation and one-hot to binary.
    always_comb begin
        pick_oh  = req & (~req + N'(1));
        any      = |req;
        pick_idx = '0;
        for (int i = 0; i < N; i++)
            if (pick_oh[i]) pick_idx = pick_idx | IW'(i);
    end
endmodule

// File: rtl/rs_station.sv
// Reservation station, two dispatch slots, two broadcast buses, one
// registered issue port. Tracks operand availability only. Assumes the
// execute side accepts one instruction every cycle.
module rs_station
    import rs_pkg::*;
#(
    parameter int N   = 8,
    localparam int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [1:0]             disp_vld,
    input  logic [1:0][TAG_W-1:0]  disp_tag_a,
    input  logic [1:0]             disp_rdy_a,
    input  logic [1:0][TAG_W-1:0]  disp_tag_b,
    input  logic [1:0]             disp_rdy_b,
    input  logic [1:0][TAG_W-1:0]  disp_dst,
    output logic                   disp_stall,
    input  logic [1:0]             cdb_vld,
    input  logic [1:0][TAG_W-1:0]  cdb_tag,
    output logic                   issue_vld,
    output logic [IW-1:0]          issue_idx,
    output logic [TAG_W-1:0]       issue_tag_a,
    output logic [TAG_W-1:0]       issue_tag_b,
    output logic [TAG_W-1:0]       issue_dst
);
    rs_ent_t [N-1:0]    ents;
    rs_ent_t [NSLOT-1:0] slot_data;
    logic [N-1:0]       entry_vld;
    logic [N-1:0]       eligible;
    logic [N-1:0]       grant0, grant1;
    logic [N-1:0]       pick_oh;
    logic               pick_any;
    logic [IW-1:0]      pick_idx;
    rs_ent_t            picked;

    // Pack each dispatch slot into an entry record.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_data[s].vld   = disp_vld[s];
            slot_data[s].rdy_a = disp_rdy_a[s];
            slot_data[s].rdy_b = disp_rdy_b[s];
            slot_data[s].tag_a = disp_tag_a[s];
            slot_data[s].tag_b = disp_tag_b[s];
            slot_data[s].dst   = disp_dst[s];
        end
    end

    // Gather per-entry valid and issue eligibility.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            entry_vld[i] = ents[i].vld;
            eligible[i]  = ents[i].vld & ents[i].rdy_a & ents[i].rdy_b;
        end
    end

    rs_alloc #(.N(N)) u_alloc (
        .free_vec (~entry_vld),
        .req      (disp_vld),
        .grant0   (grant0),
        .grant1   (grant1),
        .stall    (disp_stall)
    );

    rs_select #(.N(N)) u_sel (
        .req      (eligible),
        .pick_oh  (pick_oh),
        .any      (pick_any),
        .pick_idx (pick_idx)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_ent
            rs_entry u_ent (
                .clk     (clk),
                .rst_n   (rst_n),
                .flush   (flush),
                .wr_en   (grant0[gi] | grant1[gi]),
                .wr_data (grant0[gi] ? slot_data[0] : slot_data[1]),
                .clr     (pick_oh[gi]),
                .bvld    (cdb_vld),
                .btag    (cdb_tag),
                .ent     (ents[gi])
            );
        end
    endgenerate

    // Read out the chosen entry's record.
    always_comb begin
        picked = '0;
        for (int i = 0; i < N; i++)
            if (pick_oh[i]) picked = ents[i];
    end

    // Issue register: one instruction per cycle toward execute.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            issue_vld   <= 1'b0;
            issue_idx   <= '0;
            issue_tag_a <= '0;
            issue_tag_b <= '0;
            issue_dst   <= '0;
        end else begin
            issue_vld   <= pick_any;
            issue_idx   <= pick_idx;
            issue_tag_a <= picked.tag_a;
            issue_tag_b <= picked.tag_b;
            issue_dst   <= picked.dst;
        end
    end
endmodule

// File: rtl/rs_station_chk.sv
// Property checker for rs_station, attached by bind below.
module rs_station_chk #(
    parameter int N   = 8,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic [1:0]    disp_vld,
    input logic          disp_stall,
    input logic          issue_vld,
    input logic [IW-1:0] issue_idx,
    input logic [N-1:0]  entry_vld,
    input logic [N-1:0]  grant0,
    input logic [N-1:0]  grant1
);
    AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant0 | grant1) & entry_vld) == '0);  // R2
    AST_GRANT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant0) && $onehot0(grant1) && ((grant0 & grant1) == '0));  // R2
    AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall |-> (disp_vld != 2'b00));  // R3
    AST_ISSUED_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> !entry_vld[issue_idx]);  // R8
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && $past(issue_vld)) |-> (issue_idx != $past(issue_idx)));  // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (entry_vld == '0) && !issue_vld);  // R9
endmodule

bind rs_station rs_station_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .disp_vld   (disp_vld),
    .disp_stall (disp_stall),
    .issue_vld  (issue_vld),
    .issue_idx  (issue_idx),
    .entry_vld  (entry_vld),
    .grant0     (grant0),
    .grant1     (grant1)
);

// File: tb/sim_rs_station.sv
`timescale 1ns/1ps
module sim_rs_station;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic [1:0]      disp_vld = '0;
    logic [1:0][5:0] disp_tag_a = '0;
    logic [1:0]      disp_rdy_a = '0;
    logic [1:0][5:0] disp_tag_b = '0;
    logic [1:0]      disp_rdy_b = '0;
    logic [1:0][5:0] disp_dst = '0;
    logic            disp_stall;
    logic [1:0]      cdb_vld = '0;
    logic [1:0][5:0] cdb_tag = '0;
    logic            issue_vld;
    logic [2:0]      issue_idx;
    logic [5:0]      issue_tag_a, issue_tag_b, issue_dst;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rs_station u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_vld(disp_vld), .disp_tag_a(disp_tag_a), .disp_rdy_a(disp_rdy_a),
        .disp_tag_b(disp_tag_b), .disp_rdy_b(disp_rdy_b), .disp_dst(disp_dst),
        .disp_stall(disp_stall), .cdb_vld(cdb_vld), .cdb_tag(cdb_tag),
        .issue_vld(issue_vld), .issue_idx(issue_idx), .issue_tag_a(issue_tag_a),
        .issue_tag_b(issue_tag_b), .issue_dst(issue_dst)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        disp_vld = '0; disp_rdy_a = '0; disp_rdy_b = '0;
        disp_tag_a = '0; disp_tag_b = '0; disp_dst = '0;
        cdb_vld = '0; cdb_tag = '0; flush = 1'b0;
    endtask

    task automatic slot(input int s, input int ta, input bit ra,
                        input int tb, input bit rb, input int dst);
        disp_vld[s] = 1'b1;
        disp_tag_a[s] = 6'(ta); disp_rdy_a[s] = ra;
        disp_tag_b[s] = 6'(tb); disp_rdy_b[s] = rb;
        disp_dst[s] = 6'(dst);
    endtask

    task automatic bcast(input int b, input int t);
        cdb_vld[b] = 1'b1; cdb_tag[b] = 6'(t);
    endtask

    task automatic expect_issue(input string req, input int idx, input int dst);
        check({req, " issue_vld"}, int'(issue_vld), 1);
        check({req, " issue_idx"}, int'(issue_idx), idx);
        check({req, " issue_dst"}, int'(issue_dst), dst);
    endtask

    task automatic expect_none(input string req);
        check({req, " no issue"}, int'(issue_vld), 0);
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset();
        #1;
        check("R1 issue_vld", int'(issue_vld), 0);
        check("R1 disp_stall", int'(disp_stall), 0);
    endtask

    // R7, R8: ready dispatch shows one cycle after its write, once.
    task automatic t_basic();
        do_reset();
        slot(0, 3, 1, 4, 1, 5);
        tick(); clear_in();
        expect_none("R7 latency");
        tick();
        expect_issue("R7 ready", 0, 5);
        check("R7 tag_a", int'(issue_tag_a), 3);
        check("R7 tag_b", int'(issue_tag_b), 4);
        tick();
        expect_none("R8 once");
        tick();
        expect_none("R8 once later");
    endtask

    // R4, R6: wakeup through each bus and each source.
    task automatic t_wakeup();
        do_reset();
        slot(0, 10, 0, 1, 1, 7);
        slot(1, 2, 1, 11, 0, 8);
        tick(); clear_in();
        for (int k = 0; k < 3; k++) begin
            expect_none("R4 waiting");
            tick();
        end
        bcast(0, 12); bcast(1, 13);
        tick(); clear_in();
        tick();
        expect_none("R6 mismatch");
        bcast(0, 10);
        tick(); clear_in();
        expect_none("R4 wake latency");
        tick();
        expect_issue("R4 bus0 srcA", 0, 7);
        bcast(1, 11);
        tick(); clear_in();
        expect_none("R4 second wait");
        tick();
        expect_issue("R4 bus1 srcB", 1, 8);
    endtask

    // R5: capture of broadcasts coinciding with dispatch.
    task automatic t_bypass();
        do_reset();
        slot(0, 20, 0, 1, 1, 21);
        slot(1, 2, 1, 22, 0, 23);
        bcast(1, 20); bcast(0, 22);
        tick(); clear_in();
        tick();
        expect_issue("R5 slot0 srcA bus1", 0, 21);
        tick();
        expect_issue("R5 slot1 srcB bus0", 1, 23);
        tick();
        expect_none("R5 drained");
    endtask

    // R7: several ready in one cycle leave lowest index first.
    task automatic t_order();
        do_reset();
        slot(0, 40, 0, 1, 1, 1);
        slot(1, 40, 0, 1, 1, 2);
        tick(); clear_in();
        slot(0, 1, 1, 40, 0, 3);
        tick(); clear_in();
        bcast(0, 40);
        tick(); clear_in();
        tick(); expect_issue("R7 order 0", 0, 1);
        tick(); expect_issue("R7 order 1", 1, 2);
        tick(); expect_issue("R7 order 2", 2, 3);
        tick(); expect_none("R7 order end");
    endtask

    // R2, R3: fill and stall decisions.
    task automatic t_full();
        do_reset();
        for (int c = 0; c < 3; c++) begin
            slot(0, 50, 0, 50, 0, 40 + 2*c);
            slot(1, 50, 0, 50, 0, 41 + 2*c);
            #1; check("R3 room", int'(disp_stall), 0);
            tick(); clear_in();
        end
        slot(0, 50, 0, 50, 0, 46);
        tick(); clear_in();
        slot(0, 1, 1, 1, 1, 60);
        slot(1, 1, 1, 1, 1, 61);
        #1; check("R3 one free two asked", int'(disp_stall), 1);
        tick(); clear_in();
        slot(1, 50, 0, 50, 0, 47);
        #1; check("R3 one free one asked", int'(disp_stall), 0);
        tick(); clear_in();
        slot(0, 1, 1, 1, 1, 63);
        #1; check("R3 full", int'(disp_stall), 1);
        tick(); clear_in();
        tick();
        expect_none("R3 stalled dropped");
        bcast(1, 50);
        tick(); clear_in();
        for (int i = 0; i < 8; i++) begin
            tick();
            expect_issue("R2 fill order", i, 40 + i);
        end
        tick();
        expect_none("R3 no extra");
    endtask

    // R2: lone slot 1 takes the lowest free entry.
    task automatic t_slot1();
        do_reset();
        slot(0, 33, 0, 33, 0, 30);
        tick(); clear_in();
        slot(1, 1, 1, 1, 1, 12);
        tick(); clear_in();
        tick();
        expect_issue("R2 slot1 alone", 1, 12);
    endtask

    // R9: flush empties, drops coincident dispatch and issue.
    task automatic t_flush();
        do_reset();
        slot(0, 5, 0, 1, 1, 9);
        tick(); clear_in();
        flush = 1'b1;
        slot(0, 1, 1, 1, 1, 10);
        tick(); clear_in();
        expect_none("R9 flush");
        bcast(0, 5);
        tick(); clear_in();
        tick(); expect_none("R9 emptied");
        tick(); expect_none("R9 dropped dispatch");
        slot(0, 1, 1, 1, 1, 11);
        tick(); clear_in();
        flush = 1'b1;
        tick(); clear_in();
        expect_none("R9 issue cancelled");
        tick(); expect_none("R9 issue cancelled later");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wakeup();
        t_bypass();
        t_order();
        t_full();
        t_slot1();
        t_flush();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule